// File: doc/BRIEF.md
# Audio Receive Sample Buffer with Output Formatter

This block sits between an audio converter datapath and a CPU or DMA reader. Incoming 20-bit samples are queued in a 64-entry first-in first-out store. Each read returns the oldest sample as a 32-bit word. The word is shaped by two control bits: one selects 16-bit or 20-bit resolution, and the other selects left-justified with zero fill or right-justified with sign extension.

The block compares the fill level against a 6-bit threshold. When the level is strictly above it, a data-available interrupt and a DMA request can assert, each through its own enable. A sample that arrives while the store is full is dropped and raises a sticky overrun flag. That flag drives a separately enabled interrupt. A single write port loads all controls. A flush bit in that port empties the store, and the bit clears itself on the next cycle.

Top module: `arx_capture`

## Requirements
- R1: Samples leave in arrival order. Up to 64 are held, and `level` (0 to 64) counts the stored samples one cycle after each accepted push or pop.
- R2: With wide resolution (control bit 5 = 1) and mode bit 6 = 0, a read returns the sample in bits 31:12, with bits 11:0 zero.
- R3: With wide resolution and mode bit 6 = 1, a read returns the sample in bits 19:0, with bits 31:20 copies of sample bit 19.
- R4: With narrow resolution (bit 5 = 0) and mode 0, sample bits 19:4 appear in bits 31:16, with bits 15:0 zero.
- R5: With narrow resolution and mode 1, sample bits 19:4 appear in bits 15:0, with bits 31:16 copies of sample bit 19.
- R6: `rd_data` takes the formatted word one cycle after `rd_en`. A read of an empty store returns zero and leaves `level` unchanged.
- R7: A push while `level` is 64 is discarded and sets the overrun flag (`cfg_rdata` bit 1). The flag stays set until bit 1 is written as 1. `irq_ovr` equals the flag ANDed with enable bit 2.
- R8: `irq_avail` (enable bit 3) and `dma_req` (enable bit 4) assert only while `level` is strictly greater than the threshold in bits 12:7. Each has its own enable.
- R9: Writing 1 to bit 0 sets the flush bit for one cycle. The bit then reads 0 again, and both `level` and the overrun flag are zero.
- R10: After reset, `level`, `rd_data`, `cfg_rdata` and all request outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample push strobe |
| smp_data | input | 20 | Incoming sample |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Formatted read word |
| cfg_we | input | 1 | Control write strobe |
| cfg_wdata | input | 13 | Control write value |
| cfg_rdata | output | 13 | Control readback, bit 1 = overrun flag |
| level | output | 7 | Stored sample count |
| irq_ovr | output | 1 | Overrun interrupt |
| irq_avail | output | 1 | Data-available interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The formatter is tested in all four resolution and mode combinations. The samples are chosen so that bit 19 is set in some and clear in others, and so that the low nibble differs from zero. A wrong sign fill, a swapped justification or a dropped nibble each gives a different word. The threshold is tested at exactly the threshold and at one above it, which separates a strict comparison from an inclusive one. The store is filled to capacity, overrun by one, and drained, which checks ordering, the discard of the extra sample, and the stickiness of the flag.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int SMP_W = 20;
  localparam int NAR_W = 16;
  localparam int OUT_W = 32;
  localparam int THR_W = 6;
  localparam int CFG_W = 7 + THR_W;

  // control word bit positions
  localparam int B_FLUSH = 0;
  localparam int B_OCLR  = 1;
  localparam int B_OIE   = 2;
  localparam int B_AIE   = 3;
  localparam int B_DIE   = 4;
  localparam int B_WIDE  = 5;
  localparam int B_RJ    = 6;
  localparam int B_THR   = 7;

  typedef struct packed {
    logic [THR_W-1:0] thr;
    logic             rj;
    logic             wide;
    logic             dreq_en;
    logic             avail_ie;
    logic             ovr_ie;
  } arx_ctl_t;

  function automatic logic [OUT_W-1:0] arx_fmt(input logic [SMP_W-1:0] s,
                                               input logic wide,
                                               input logic rj);
    logic [NAR_W-1:0] n;
    n = s[SMP_W-1 -: NAR_W];
    case ({wide, rj})
      2'b10:   arx_fmt = {s, {(OUT_W-SMP_W){1'b0}}};
      2'b11:   arx_fmt = {{(OUT_W-SMP_W){s[SMP_W-1]}}, s};
      2'b00:   arx_fmt = {n, {(OUT_W-NAR_W){1'b0}}};
      default: arx_fmt = {{(OUT_W-NAR_W){s[SMP_W-1]}}, n};
    endcase
  endfunction
endpackage

// File: rtl/arx_rst_sync.sv
module arx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/arx_store.sv
module arx_store #(
  parameter int DEPTH = 64,
  parameter int DW    = 20,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] din,
  input  logic          pop,
  input  logic          flush,
  output logic [DW-1:0] head,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (flush) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + 1'b1;
      if (do_pop)  rd_d = rd_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign head  = mem[rd_q];
  assign level = lvl_q;
endmodule

// File: rtl/arx_ctrl.sv
module arx_ctrl
  import arx_pkg::*;
#(
  parameter int LW = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             ovr_hit,
  input  logic [LW-1:0]    level,
  output arx_ctl_t         ctl,
  output logic             flush,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             irq_ovr,
  output logic             irq_avail,
  output logic             dma_req
);
  arx_ctl_t ctl_q, ctl_d;
  logic     fl_q, fl_d;
  logic     ovr_q, ovr_d;
  logic     above;

  always_comb begin
    ctl_d = ctl_q;
    fl_d  = 1'b0;
    ovr_d = ovr_q;
    if (cfg_we) begin
      ctl_d.thr      = cfg_wdata[B_THR +: THR_W];
      ctl_d.rj       = cfg_wdata[B_RJ];
      ctl_d.wide     = cfg_wdata[B_WIDE];
      ctl_d.dreq_en  = cfg_wdata[B_DIE];
      ctl_d.avail_ie = cfg_wdata[B_AIE];
      ctl_d.ovr_ie   = cfg_wdata[B_OIE];
      fl_d           = cfg_wdata[B_FLUSH];
      if (cfg_wdata[B_OCLR]) ovr_d = 1'b0;
    end
    if (ovr_hit) ovr_d = 1'b1;
    if (fl_q)    ovr_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      fl_q  <= 1'b0;
      ovr_q <= 1'b0;
    end else begin
      ctl_q <= ctl_d;
      fl_q  <= fl_d;
      ovr_q <= ovr_d;
    end
  end

  assign above     = (level > LW'(ctl_q.thr));
  assign irq_avail = above && ctl_q.avail_ie;
  assign dma_req   = above && ctl_q.dreq_en;
  assign irq_ovr   = ovr_q && ctl_q.ovr_ie;
  assign ctl       = ctl_q;
  assign flush     = fl_q;
  assign cfg_rdata = {ctl_q.thr, ctl_q.rj, ctl_q.wide, ctl_q.dreq_en,
                      ctl_q.avail_ie, ctl_q.ovr_ie, ovr_q, fl_q};
endmodule

// File: rtl/arx_rdport.sv
module arx_rdport
  import arx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             empty,
  input  logic             flush,
  input  logic [SMP_W-1:0] head,
  input  logic             wide,
  input  logic             rj,
  output logic [OUT_W-1:0] rd_data
);
  logic [OUT_W-1:0] rd_q, rd_d;

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      if (empty || flush) rd_d = '0;
      else                rd_d = arx_fmt(head, wide, rj);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/arx_capture.sv
module arx_capture
  import arx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic [SMP_W-1:0]        smp_data,
  input  logic                    rd_en,
  output logic [OUT_W-1:0]        rd_data,
  input  logic                    cfg_we,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output logic [CFG_W-1:0]        cfg_rdata,
  output logic [$clog2(DEPTH):0]  level,
  output logic                    irq_ovr,
  output logic                    irq_avail,
  output logic                    dma_req
);
  localparam int LW = $clog2(DEPTH) + 1;

  logic             rst_sn;
  logic             flush, full, empty;
  logic [SMP_W-1:0] head;
  arx_ctl_t         ctl;

  arx_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  arx_store #(.DEPTH(DEPTH), .DW(SMP_W)) i_store (
    .clk(clk), .rst_n(rst_sn), .push(smp_valid), .din(smp_data),
    .pop(rd_en), .flush(flush), .head(head), .level(level),
    .full(full), .empty(empty)
  );

  arx_ctrl #(.LW(LW)) i_ctrl (
    .clk(clk), .rst_n(rst_sn), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ovr_hit(smp_valid && full && !flush), .level(level), .ctl(ctl),
    .flush(flush), .cfg_rdata(cfg_rdata), .irq_ovr(irq_ovr),
    .irq_avail(irq_avail), .dma_req(dma_req)
  );

  arx_rdport i_rd (
    .clk(clk), .rst_n(rst_sn), .rd_en(rd_en), .empty(empty), .flush(flush),
    .head(head), .wide(ctl.wide), .rj(ctl.rj), .rd_data(rd_data)
  );
endmodule

// File: rtl/arx_capture_chk.sv
module arx_capture_chk
  import arx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_valid,
  input logic                   rd_en,
  input logic [OUT_W-1:0]       rd_data,
  input logic                   cfg_we,
  input logic [CFG_W-1:0]       cfg_rdata,
  input logic [$clog2(DEPTH):0] level,
  input logic                   irq_ovr,
  input logic                   irq_avail,
  input logic                   dma_req
);
  localparam int LW = $clog2(DEPTH) + 1;

  // R1
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R1
  level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[B_FLUSH] |=> ({1'b0, level} <= {1'b0, $past(level)} + 1'b1) &&
                            ({1'b0, level} + 1'b1 >= {1'b0, $past(level)}));

  // R6
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && level == '0) |=> (rd_data == '0) && (level <= 1));

  // R7
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && level == LW'(DEPTH) && !cfg_rdata[B_FLUSH]) |=>
      cfg_rdata[B_OCLR] && level == LW'(DEPTH) - (LW)'($past(rd_en)));

  // R7
  ovr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovr |-> cfg_rdata[B_OCLR] && cfg_rdata[B_OIE]);

  // R8
  avail_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_avail || dma_req) |-> level > LW'(cfg_rdata[B_THR +: THR_W]));

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[B_FLUSH] && !cfg_we) |=>
      !cfg_rdata[B_FLUSH] && level == '0 && !cfg_rdata[B_OCLR]);
endmodule

bind arx_capture arx_capture_chk #(.DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .rd_en(rd_en),
  .rd_data(rd_data), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata), .level(level),
  .irq_ovr(irq_ovr), .irq_avail(irq_avail), .dma_req(dma_req)
);

// File: tb/test_arx_capture.sv
`timescale 1ns/1ps
module test_arx_capture;
  import arx_pkg::*;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             smp_valid = 1'b0;
  logic [SMP_W-1:0] smp_data = '0;
  logic             rd_en = 1'b0;
  logic [OUT_W-1:0] rd_data;
  logic             cfg_we = 1'b0;
  logic [CFG_W-1:0] cfg_wdata = '0;
  logic [CFG_W-1:0] cfg_rdata;
  logic [6:0]       level;
  logic             irq_ovr, irq_avail, dma_req;

  int checks = 0;
  int errors = 0;
  logic [SMP_W-1:0] mdl[$];
  logic [OUT_W-1:0] exp_q[$];
  string            tag_q[$];
  logic cur_wide = 1'b0, cur_rj = 1'b0;
  logic rd_seen = 1'b0;

  always #5 clk = ~clk;

  arx_capture i_arx_capture (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_en(rd_en), .rd_data(rd_data), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .level(level), .irq_ovr(irq_ovr),
    .irq_avail(irq_avail), .dma_req(dma_req)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] expect_fmt(logic [SMP_W-1:0] s, logic w, logic r);
    if (w && !r)  return {s, 12'h000};
    if (w && r)   return {{12{s[19]}}, s};
    if (!w && !r) return {s[19:4], 16'h0000};
    return {{16{s[19]}}, s[19:4]};
  endfunction

  function automatic logic [CFG_W-1:0] cw(bit fl, bit clr, bit oie, bit aie,
                                          bit die, bit w, bit r, logic [5:0] thr);
    return {thr, r, w, die, aie, oie, clr, fl};
  endfunction

  task automatic cfg(logic [CFG_W-1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    cur_wide = v[B_WIDE]; cur_rj = v[B_RJ];
    @(negedge clk);
    cfg_we = 1'b0;
    if (v[B_FLUSH]) mdl.delete();
  endtask

  task automatic push_s(logic [SMP_W-1:0] d);
    @(negedge clk);
    smp_valid = 1'b1; smp_data = d;
    if (mdl.size() < 64) mdl.push_back(d);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic read_w(string tag);
    @(negedge clk);
    rd_en = 1'b1;
    if (mdl.size() == 0) exp_q.push_back('0);
    else exp_q.push_back(expect_fmt(mdl.pop_front(), cur_wide, cur_rj));
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [OUT_W-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(rd_data == e, t, rd_data, e);
    end
  end

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(level == 0, "R10 level", level, 0);
    chk(cfg_rdata == 0, "R10 cfg", cfg_rdata, 0);
    chk({irq_ovr, irq_avail, dma_req} == 0, "R10 req", {irq_ovr, irq_avail, dma_req}, 0);
    chk(rd_data == 0, "R10 rd_data", rd_data, 0);

    // R2 wide left-justified
    cfg(cw(0,0,0,0,0,1,0,6'd0));
    push_s(20'hABCDE); push_s(20'h12345); push_s(20'h80001);
    chk(level == 3, "R1 level after three", level, 3);
    read_w("R2 a"); read_w("R2 b"); read_w("R2 c");
    chk(level == 0, "R1 level drained", level, 0);

    // R6 empty read
    read_w("R6 empty word");
    chk(level == 0, "R6 level unchanged", level, 0);

    // R3 wide right-justified, both signs
    cfg(cw(0,0,0,0,0,1,1,6'd0));
    push_s(20'h80001); push_s(20'h7FFFF);
    read_w("R3 neg"); read_w("R3 pos");

    // R4 narrow left
    cfg(cw(0,0,0,0,0,0,0,6'd0));
    push_s(20'hF1234); push_s(20'h0ABC7);
    read_w("R4 a"); read_w("R4 b");

    // R5 narrow right
    cfg(cw(0,0,0,0,0,0,1,6'd0));
    push_s(20'h8ABCD); push_s(20'h3ABCD);
    read_w("R5 neg"); read_w("R5 pos");

    // R8 threshold strictly greater
    cfg(cw(0,0,0,1,1,1,0,6'd5));
    for (int i = 0; i < 5; i++) push_s(20'(i * 20'h1357 + 7));
    chk(!irq_avail && !dma_req, "R8 equal no trigger", {irq_avail, dma_req}, 0);
    push_s(20'h55555);
    chk(irq_avail && dma_req, "R8 above triggers", {irq_avail, dma_req}, 3);
    cfg(cw(0,0,0,1,0,1,0,6'd5));
    chk(irq_avail && !dma_req, "R8 dma disabled", {irq_avail, dma_req}, 2);
    cfg(cw(0,0,0,0,1,1,0,6'd5));
    chk(!irq_avail && dma_req, "R8 irq disabled", {irq_avail, dma_req}, 1);

    // R1 fill to capacity, R7 overrun
    cfg(cw(0,0,1,1,1,1,0,6'd5));
    for (int i = 0; i < 58; i++) push_s(20'(i * 20'h0F0F3 + 20'h100));
    chk(level == 64, "R1 full level", level, 64);
    chk(cfg_rdata[1] == 0, "R7 no overrun yet", cfg_rdata[1], 0);
    push_s(20'hDEAD0);
    chk(level == 64, "R7 level held", level, 64);
    chk(cfg_rdata[1] == 1, "R7 flag set", cfg_rdata[1], 1);
    chk(irq_ovr == 1, "R7 irq on", irq_ovr, 1);
    cfg(cw(0,0,0,1,1,1,0,6'd5));
    chk(irq_ovr == 0 && cfg_rdata[1] == 1, "R7 irq masked flag sticky", {irq_ovr, cfg_rdata[1]}, 1);
    cfg(cw(0,1,1,1,1,1,0,6'd5));
    chk(cfg_rdata[1] == 0 && irq_ovr == 0, "R7 cleared", {irq_ovr, cfg_rdata[1]}, 0);
    push_s(20'hBEEF1);
    chk(cfg_rdata[1] == 1, "R7 set again", cfg_rdata[1], 1);
    for (int i = 0; i < 64; i++) read_w("R1 order");
    chk(level == 0, "R1 empty after drain", level, 0);
    chk(cfg_rdata[1] == 1, "R7 flag sticky after drain", cfg_rdata[1], 1);

    // R9 flush
    push_s(20'h11111); push_s(20'h22222); push_s(20'h33333);
    cfg(cw(1,0,1,1,1,1,0,6'd5));
    chk(cfg_rdata[0] == 1, "R9 flush bit set", cfg_rdata[0], 1);
    @(negedge clk);
    chk(cfg_rdata[0] == 0, "R9 flush self-clear", cfg_rdata[0], 0);
    chk(level == 0, "R9 emptied", level, 0);
    chk(cfg_rdata[1] == 0, "R9 overrun cleared", cfg_rdata[1], 0);
    read_w("R9 read after flush");
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule